// File: doc/BRIEF.md
# Pseudo-SRAM Burst Controller with Stall Tracking

This block sits on the host side of a pseudo-SRAM. It turns requests from an internal valid/ready port into memory cycles. Each request carries a start word address, a beat count and a write flag. Synchronous bursts run on a gated memory clock and start with one address-latch cycle. After that the controller waits a latency and then moves one word per beat. The address counts up by one word per beat.

The controller has two synchronous modes. In tracking mode it obeys the shared, wired-OR stall line. Any device on the bus may raise this line, and the controller then holds the beat and keeps chip enable low. A configuration bit picks one of two stall timings: the stall takes effect in the same clock, or one clock later. In fixed-latency mode the stall line is ignored. The controller counts cycles instead, and closes the burst itself at every row boundary, so that the remaining beats go out as a fresh burst.

A mixed-mode setting turns every beat into an asynchronous access of fixed length with the memory clock held low. In fixed-latency mode, chip enable may stay low from one such access to the next. A counter watches how long chip enable has been low in one stretch, and the controller inserts a single high clock before that stretch would exceed the configured maximum.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, the outputs are idle: mem_ce_n=1, mem_clk_en=0, mem_dq_oe=0, req_ready=1, and neither beat flag is raised.
- R2: A synchronous burst starts with one cycle that has mem_adv_n=0 and mem_ce_n=0. In that cycle mem_addr holds the start address and the memory clock is enabled. No beat occurs in the LATENCY-1 cycles after the address cycle. mem_we_n is 0 throughout a write. Each beat moves the word whose address is one higher than the previous beat's.
- R3: In tracking mode (cfg_fixed_lat=0) a data cycle is a stall when mem_wait is 1. With cfg_wait_same=1 this is mem_wait in the same cycle; with cfg_wait_same=0 it is mem_wait in the previous cycle. A stall cycle moves no beat, every other data cycle moves one, and mem_ce_n stays 0 through stalls.
- R4: In fixed-latency mode (cfg_fixed_lat=1) mem_wait has no effect, and a beat occurs in every cycle from LATENCY cycles after the address cycle onward. When a beat falls on the last word of a row (the low log2(ROW_WORDS) address bits all 1) and beats remain, the next cycle has mem_ce_n=1. The cycle after that is a new address cycle for the next word.
- R5: On a read beat, rd_valid=1 and rd_data equals mem_dq_in. On a write beat, wr_ready=1, mem_dq_oe=1 and mem_dq_out equals wr_data.
- R6: With cfg_async=1, each beat is an access of ASYNC_CYC cycles. mem_clk_en stays 0 and mem_wait has no effect. The beat falls in the last cycle of the access.
- R7: In an asynchronous access, mem_adv_n is 0 only in the access's first cycle. The exception is a write with cfg_adv_hold=1, where mem_adv_n is 0 in every cycle.
- R8: Between asynchronous accesses of one request, mem_ce_n goes to 1 for exactly one cycle in tracking mode. In fixed-latency mode it stays 0, unless the low stretch plus another ASYNC_CYC cycles would exceed CEM_MAX, in which case one high cycle is inserted. A low stretch never exceeds CEM_MAX cycles.
- R9: Each request moves exactly req_len beats (req_len of 1 or more). The final beat leads straight to idle, with no row split even on a row's last word, and done is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one memory clock per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fixed_lat | input | 1 | 1 = count cycles and ignore stalls; 0 = track mem_wait |
| cfg_wait_same | input | 1 | 1 = stall in the cycle mem_wait is high; 0 = one cycle later |
| cfg_async | input | 1 | 1 = asynchronous accesses with the clock held low |
| cfg_adv_hold | input | 1 | 1 = keep address latch low for a whole asynchronous write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of beats |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_data | input | DW | Write word for the next beat |
| wr_ready | output | 1 | Write beat taken this cycle |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | Read beat this cycle |
| done | output | 1 | One-cycle pulse after a request's last beat |
| mem_clk_en | output | 1 | Memory clock runs this cycle |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address latch, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Word address |
| mem_dq_out | output | DW | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data from memory |
| mem_wait | input | 1 | Shared wired-OR stall line |

## Verification
Two decisions can fall on the same beat in fixed-latency mode: ending the request and splitting the burst at a row's last word. Directed requests provoke this by choosing the start address and length so that the final beat lands on a row's last word. The bench then expects done and idle in the next cycle, with no extra high chip-enable cycle and no new address cycle. Other directed requests cross a row one beat before their end, so the split and the final beat fall close together. Each new request is presented in the same cycle as the previous request's done pulse, which tests acceptance alongside completion.

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int LW        = 8,
  parameter int LATENCY   = 3,
  parameter int ROW_WORDS = 16,
  parameter int ASYNC_CYC = 3,
  parameter int CEM_MAX   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fixed_lat,
  input  logic          cfg_wait_same,
  input  logic          cfg_async,
  input  logic          cfg_adv_hold,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          done,
  output logic          mem_clk_en,
  output logic          mem_ce_n,
  output logic          mem_adv_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_wait
);
  localparam int RB   = $clog2(ROW_WORDS);
  localparam int CMAX = (LATENCY > ASYNC_CYC) ? LATENCY : ASYNC_CYC;
  localparam int CNW  = $clog2(CMAX + 1);
  localparam int CRW  = $clog2(CEM_MAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LAT, S_DATA, S_GAP, S_ASYNC} st_t;

  st_t           state;
  logic [AW-1:0] addr;
  logic [LW-1:0] left;
  logic          is_wr;
  logic [CNW-1:0] cnt;
  logic [CRW-1:0] ce_run;
  logic          wait_q;

  logic wait_eff, sync_on, ce_low, beat, beat_sync, beat_async, last, row_end, ce_over;

  assign wait_eff   = cfg_wait_same ? mem_wait : wait_q;
  assign sync_on    = (state == S_ADDR) || (state == S_LAT) || (state == S_DATA);
  assign ce_low     = sync_on || (state == S_ASYNC);
  assign beat_sync  = (state == S_DATA) && (cfg_fixed_lat || !wait_eff);
  assign beat_async = (state == S_ASYNC) && (cnt == CNW'(ASYNC_CYC - 1));
  assign beat       = beat_sync || beat_async;
  assign last       = (left == LW'(1));
  assign row_end    = &addr[RB-1:0];
  assign ce_over    = (32'(ce_run) + 32'(ASYNC_CYC) + 32'd1) > 32'(CEM_MAX);

  assign req_ready  = (state == S_IDLE);
  assign mem_ce_n   = !ce_low;
  assign mem_clk_en = sync_on;
  assign mem_adv_n  = !((state == S_ADDR) ||
                        ((state == S_ASYNC) && ((cnt == '0) || (is_wr && cfg_adv_hold))));
  assign mem_we_n   = !(is_wr && ce_low);
  assign mem_addr   = addr;
  assign mem_dq_oe  = is_wr && ((state == S_DATA) || (state == S_ASYNC));
  assign mem_dq_out = wr_data;
  assign wr_ready   = beat && is_wr;
  assign rd_valid   = beat && !is_wr;
  assign rd_data    = mem_dq_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr   <= '0;
      left   <= '0;
      is_wr  <= 1'b0;
      cnt    <= '0;
      ce_run <= '0;
      wait_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      wait_q <= mem_wait;
      done   <= beat && last;
      if (!ce_low)            ce_run <= '0;
      else if (ce_run != '1)  ce_run <= ce_run + CRW'(1);
      case (state)
        S_IDLE: if (req_valid) begin
          addr  <= req_addr;
          left  <= req_len;
          is_wr <= req_write;
          cnt   <= '0;
          state <= cfg_async ? S_ASYNC : S_ADDR;
        end
        S_ADDR: begin
          cnt   <= CNW'(1);
          state <= (LATENCY <= 1) ? S_DATA : S_LAT;
        end
        S_LAT: begin
          cnt <= cnt + CNW'(1);
          if (cnt == CNW'(LATENCY - 1)) state <= S_DATA;
        end
        S_DATA: if (beat) begin
          addr <= addr + AW'(1);
          left <= left - LW'(1);
          if (last)                          state <= S_IDLE;
          else if (cfg_fixed_lat && row_end) state <= S_GAP;
        end
        S_GAP: begin
          cnt   <= '0;
          state <= cfg_async ? S_ASYNC : S_ADDR;
        end
        S_ASYNC: if (beat) begin
          cnt  <= '0;
          addr <= addr + AW'(1);
          left <= left - LW'(1);
          if (last)                          state <= S_IDLE;
          else if (!cfg_fixed_lat || ce_over) state <= S_GAP;
        end else begin
          cnt <= cnt + CNW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_clk_en && !mem_dq_oe)); // R1
  AST_CLK_STARTS_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_clk_en) |-> !mem_adv_n); // R2
  AST_STALL_KEEPS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && !cfg_fixed_lat && wait_eff) |=> !mem_ce_n); // R3
  AST_ROW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_sync && cfg_fixed_lat && row_end && !last) |=> (mem_ce_n && !done)); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (mem_dq_oe && !rd_valid)); // R5
  AST_ASYNC_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_low && !mem_clk_en) |-> (state == S_ASYNC)); // R6
  AST_CE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ASYNC) |-> (32'(ce_run) < 32'(CEM_MAX))); // R8
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(beat) && req_ready)); // R9
endmodule

// File: tb/psram_burst_ctrl_bench.sv
`timescale 1ns/1ps
module psram_burst_ctrl_bench;
  localparam int AW = 16, DW = 16, LW = 8, LAT = 3, ROW = 16, ACYC = 3, CEM = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_fixed_lat = 0, cfg_wait_same = 0, cfg_async = 0, cfg_adv_hold = 0;
  logic req_valid = 0, req_write = 0, mem_wait = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [DW-1:0] wr_data = '0;
  logic req_ready, wr_ready, rd_valid, done, mem_clk_en, mem_ce_n, mem_adv_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int tests = 0, fails = 0, done_cnt = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rpat(input logic [15:0] a);
    return (a * 16'd7) ^ 16'hC35A;
  endfunction
  function automatic logic [15:0] wpat(input int i);
    return 16'(i * 16'h1111 + 16'h0203);
  endfunction

  assign mem_dq_in = rpat(mem_addr);

  psram_burst_ctrl #(.AW(AW), .DW(DW), .LW(LW), .LATENCY(LAT), .ROW_WORDS(ROW),
                     .ASYNC_CYC(ACYC), .CEM_MAX(CEM)) u_psram_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_fixed_lat(cfg_fixed_lat), .cfg_wait_same(cfg_wait_same),
    .cfg_async(cfg_async), .cfg_adv_hold(cfg_adv_hold), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  // stall line driven just after each rising edge
  bit wcur = 0, wprev = 0;
  initial forever begin
    @(posedge clk); #1;
    wprev = wcur;
    wcur = ($urandom % 3) == 0;
    mem_wait = wcur;
  end

  // monitor and reference model, sampling on falling edges
  bit active = 0, wr_q, async_q, fixed_q, same_q, hold_q, exp_gap, prev_ce_hi, exp_done = 0;
  logic [15:0] exp_addr;
  int beats, len_q, sa, acyc, run;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin : mon
      bit b, expb, stall;
      b = rd_valid | wr_ready;
      stall = same_q ? wcur : wprev;
      chk("R9 done pulse", done, exp_done);
      exp_done = 0;
      if (!active) begin
        chk("R1 idle outputs", {mem_ce_n, mem_clk_en, mem_dq_oe, b, req_ready}, 5'b10001);
      end else begin
        chk(async_q ? "R8 chip enable" : "R4 chip enable", mem_ce_n, exp_gap);
        if (mem_ce_n) begin
          chk("R4 no beat while deselected", b, 0);
          prev_ce_hi = 1; run = 0; acyc = 0; exp_gap = 0;
        end else begin
          run++;
          if (!async_q) begin
            if (!mem_adv_n) sa = 0; else sa++;
            chk("R2 address latch", mem_adv_n, !prev_ce_hi);
            chk("R2 clock on", mem_clk_en, 1);
            chk("R2 write enable", mem_we_n, !wr_q);
            if (!mem_adv_n) chk("R2 start address", mem_addr, exp_addr);
            expb = (sa >= LAT) && (fixed_q || !stall);
            chk(fixed_q ? "R4 beat timing" : "R3 beat timing", b, expb);
          end else begin
            acyc++;
            chk("R6 clock low", mem_clk_en, 0);
            chk("R7 address latch", mem_adv_n, !((acyc == 1) || (wr_q && hold_q)));
            chk("R6 write enable", mem_we_n, !wr_q);
            chk("R8 low stretch", run <= CEM, 1);
            expb = (acyc == ACYC);
            chk("R6 beat timing", b, expb);
          end
          prev_ce_hi = 0;
          exp_gap = 0;
          if (b) begin
            chk("R5 beat direction", {rd_valid, wr_ready}, {!wr_q, wr_q});
            chk("R2 beat address", mem_addr, exp_addr);
            if (wr_q) chk("R5 write data", {mem_dq_oe, mem_dq_out}, {1'b1, wr_data});
            else      chk("R5 read data", rd_data, rpat(exp_addr));
            beats++; acyc = 0;
            if (beats == len_q) begin
              active = 0; exp_done = 1; done_cnt++;
            end else begin
              exp_gap = async_q ? (!fixed_q || (run + ACYC > CEM))
                                : (fixed_q && ((exp_addr % ROW) == ROW - 1));
              wr_data = wpat(beats);
            end
            exp_addr++;
          end
        end
      end
      if (req_valid && req_ready) begin
        active = 1; exp_addr = req_addr; len_q = int'(req_len); wr_q = req_write;
        async_q = cfg_async; fixed_q = cfg_fixed_lat; same_q = cfg_wait_same; hold_q = cfg_adv_hold;
        prev_ce_hi = 1; exp_gap = 0; beats = 0; run = 0; acyc = 0; sa = 0;
        wr_data = wpat(0);
      end
    end
  end

  task automatic run_req(input bit fx, input bit sm, input bit as, input bit hd,
                         input logic [15:0] a, input int n, input bit w);
    int target;
    target = done_cnt + 1;
    @(posedge clk); #1;
    cfg_fixed_lat = fx; cfg_wait_same = sm; cfg_async = as; cfg_adv_hold = hd;
    req_addr = a; req_len = LW'(n); req_write = w; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    wait (done_cnt == target);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    // R9 final beat on a row's last word: no split
    run_req(1, 0, 0, 0, 16'h001C, 4, 0);
    // R4 crossing a row with one beat left after the split
    run_req(1, 0, 0, 0, 16'h003D, 4, 1);
    run_req(1, 1, 0, 0, 16'h0048, 25, 0);
    // R3 both stall timings
    run_req(0, 1, 0, 0, 16'h1200, 10, 0);
    run_req(0, 0, 0, 0, 16'h130E, 10, 1);
    // R6 R7 R8 mixed-mode accesses
    run_req(1, 0, 1, 0, 16'h0400, 9, 0);
    run_req(0, 0, 1, 1, 16'h0500, 3, 1);
    run_req(1, 0, 1, 0, 16'h0600, 4, 1);
    run_req(1, 1, 1, 1, 16'h0700, 7, 1);
    for (int i = 0; i < 60; i++) begin
      bit as;
      as = ($urandom % 3) == 0;
      run_req($urandom % 2, $urandom % 2, as, $urandom % 2, 16'($urandom),
              as ? 1 + ($urandom % 8) : 1 + ($urandom % 20), $urandom % 2);
    end
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule